// File: doc/BRIEF.md
# Prefetching Write-Through Cache Tag Controller

This block keeps the tag side of a single-level cache. It holds valid bits, tags and least-recently-used state, but no data. Each access arrives through a valid/ready handshake with a read/write flag and a 48-bit byte address. The block answers with a hit or miss response and emits one-cycle memory-read and memory-write event pulses, each carrying a block-aligned address. Four saturating counters track hits, misses, memory reads and memory writes. Callers with narrower addresses zero-extend them onto the 48-bit port.

Total size, block size and way count are parameters, so a direct-mapped cache and a fully associative cache are the two ends of one design. Writes always go through to memory. A write miss first allocates the line with a read. When the prefetch input is high at the time an access is accepted, a demand miss also looks up the next sequential block. That block is fetched and made most recently used if it is absent, and it is left untouched if it is already present.

Top module: `pwc_cache_ctrl`

## Requirements
- R1: After reset all four counters read 0, `req_ready` is high, `resp_valid` is low, every line is invalid, and the first access after reset therefore misses.
- R2: An address splits into a byte offset (low log2(BLOCK_BYTES) bits), a set index (next log2(sets) bits) and a tag (remaining upper bits), so two addresses that differ only in the offset hit the same line.
- R3: Replacement within a set is least-recently-used. A hit or a demand fill makes that line the most recent. With 2 ways, the order A, B, A, C evicts B.
- R4: Every accepted write, hit or miss, produces exactly one `mem_wr` pulse, in the same cycle as its response.
- R5: A read miss produces one `mem_rd` pulse and a write miss produces one `mem_rd` and one `mem_wr` pulse, all in the response cycle. A hit produces no demand `mem_rd`.
- R6: With prefetch enabled at acceptance, and only on a demand miss, the block at (missed block address + BLOCK_BYTES) mod 2^48 is looked up in the cycle after the response. If that block is absent, its `mem_rd` pulse carries that address on `mem_addr`.
- R7: A prefetch target that is already resident issues no `mem_rd` and leaves its set's LRU order unchanged.
- R8: An absent prefetch target is filled into the LRU victim of its set and becomes most recently used. It adds to the read counter but not to the hit or miss counters.
- R9: A fill uses an invalid way of the set before it evicts any valid line.
- R10: `resp_valid` pulses two cycles after the accepting edge. `req_ready` stays low from acceptance until the access, including any prefetch lookup, is complete.
- R11: The counters are CNT_W bits wide, count up by at most one per cycle, and hold at all-ones instead of wrapping.
- R12: WAYS = 1 gives a direct-mapped cache and WAYS = CACHE_BYTES/BLOCK_BYTES gives a fully associative cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_enable | input | 1 | Enables next-block prefetch for the access being accepted |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 48 | Byte address of the access |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response was a hit |
| mem_rd | output | 1 | Memory-read event pulse (demand fill or prefetch fill) |
| mem_wr | output | 1 | Memory-write event pulse |
| mem_addr | output | 48 | Block-aligned address of the current memory event |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| rd_count | output | CNT_W | Saturating memory-read counter |
| wr_count | output | CNT_W | Saturating memory-write counter |

## Verification
The main table first runs a stream without prefetch: offset-only changes, a write miss into an empty way, and the A, B, A, C conflict, which separates true LRU from FIFO or random eviction. It then enables prefetch and steers targets so that one lands on a resident line and another on an absent one. A later hit on the line the resident prefetch would have touched shows whether that lookup wrongly updated the LRU order. Directed cases cover reset, a prefetch from the top block that must wrap to address 0, and an alternating two-block conflict run on direct-mapped, 2-way and fully associative instances, where the direct-mapped instance also drives its 3-bit counters into saturation.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_PREF   = 2'd2
  } pwc_state_e;

  localparam int NUM_CNT = 4;
  localparam int CNT_HIT  = 0;
  localparam int CNT_MISS = 1;
  localparam int CNT_RD   = 2;
  localparam int CNT_WR   = 3;
endpackage

// File: rtl/pwc_addr_split.sv
// Splits a byte address into set index and tag (R2).
module pwc_addr_split #(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  parameter int IDX_WS = 2,
  parameter int TAG_W  = 44
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_WS-1:0] idx,
  output logic [TAG_W-1:0]  tag
);
  generate
    if (IDX_W == 0) begin : g_one_set
      assign idx = '0;
    end else begin : g_sets
      assign idx = addr[OFF_W +: IDX_W];
    end
  endgenerate

  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/pwc_tag_array.sv
// Valid bits, tags and per-way LRU ages for every set.
// Age 0 marks the most recent way and WAYS-1 the least recent (R3).
module pwc_tag_array #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 44,
  parameter int IDX_WS = 2,
  parameter int WAY_WS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_WS-1:0] lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              upd_en,
  input  logic              upd_fill,
  input  logic [WAY_WS-1:0] upd_way,
  output logic              hit,
  output logic [WAY_WS-1:0] hit_way,
  output logic [WAY_WS-1:0] victim_way
);
  localparam int AGE_W = WAY_WS;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_q   [SETS][WAYS];

  logic              inv_any;
  logic [WAY_WS-1:0] inv_way;
  logic [WAY_WS-1:0] lru_way;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_WS'(w);
      end
    end
  end

  // Lowest-numbered invalid way wins (R9); otherwise the oldest way.
  always_comb begin
    inv_any = 1'b0;
    inv_way = '0;
    lru_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[lk_idx][w]) begin
        inv_any = 1'b1;
        inv_way = WAY_WS'(w);
      end
      if (age_q[lk_idx][w] == OLDEST) begin
        lru_way = WAY_WS'(w);
      end
    end
    victim_way = inv_any ? inv_way : lru_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          age_q[s][w]   <= AGE_W'(w);
        end
      end
    end else if (upd_en) begin
      if (upd_fill) begin
        valid_q[lk_idx][upd_way] <= 1'b1;
      end
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_WS'(w) == upd_way) begin
          age_q[lk_idx][w] <= '0;
        end else if (age_q[lk_idx][w] < age_q[lk_idx][upd_way]) begin
          age_q[lk_idx][w] <= age_q[lk_idx][w] + 1'b1;
        end
      end
    end
  end

  // Tags carry no reset so the array can map onto plain storage.
  always_ff @(posedge clk) begin
    if (upd_en && upd_fill) begin
      tag_q[lk_idx][upd_way] <= lk_tag;
    end
  end
endmodule

// File: rtl/pwc_sat_counter.sv
// Event counter that holds at all-ones (R11).
module pwc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != '1)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/pwc_cache_ctrl.sv
// Tag controller for a write-through LRU cache with next-block prefetch.
module pwc_cache_ctrl
  import pwc_pkg::*;
#(
  parameter int CACHE_BYTES = 32,
  parameter int BLOCK_BYTES = 4,
  parameter int WAYS        = 2,
  parameter int ADDR_W      = 48,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int LINES  = CACHE_BYTES / BLOCK_BYTES;
  localparam int SETS   = LINES / WAYS;
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int IDX_WS = (IDX_W == 0) ? 1 : IDX_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int WAY_WS = (WAY_W == 0) ? 1 : WAY_W;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W  = ADDR_W - OFF_W;

  pwc_state_e        state_q;
  logic [BLK_W-1:0]  blk_q;
  logic              wr_q;
  logic              pf_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_WS-1:0] lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit;
  logic [WAY_WS-1:0] hit_way;
  logic [WAY_WS-1:0] victim_way;
  logic              in_demand;
  logic              in_pref;
  logic              upd_en;
  logic              fill_rd;

  logic              resp_valid_q, resp_hit_q, mem_rd_q, mem_wr_q;
  logic [ADDR_W-1:0] mem_addr_q;

  assign lk_addr   = ADDR_W'(blk_q) << OFF_W;
  assign in_demand = (state_q == ST_DEMAND);
  assign in_pref   = (state_q == ST_PREF);
  // A resident prefetch target touches nothing (R7).
  assign upd_en    = in_demand || (in_pref && !hit);
  assign fill_rd   = upd_en && !hit;

  pwc_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .IDX_WS(IDX_WS), .TAG_W(TAG_W)
  ) u_split (
    .addr (lk_addr),
    .idx  (lk_idx),
    .tag  (lk_tag)
  );

  pwc_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
    .IDX_WS(IDX_WS), .WAY_WS(WAY_WS)
  ) u_tags (
    .clk        (clk),
    .rst        (rst),
    .lk_idx     (lk_idx),
    .lk_tag     (lk_tag),
    .upd_en     (upd_en),
    .upd_fill   (!hit),
    .upd_way    (hit ? hit_way : victim_way),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  // Sequencer: accept, demand lookup, optional prefetch lookup (R10).
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      wr_q    <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_DEMAND;
            blk_q   <= req_addr[ADDR_W-1:OFF_W];
            wr_q    <= req_write;
            pf_q    <= pf_enable;
          end
        end
        ST_DEMAND: begin
          if (!hit && pf_q) begin
            state_q <= ST_PREF;
            blk_q   <= blk_q + 1'b1;   // wraps modulo 2^48 (R6)
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  // Registered event outputs (R4, R5, R6).
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      mem_rd_q     <= 1'b0;
      mem_wr_q     <= 1'b0;
      mem_addr_q   <= '0;
    end else begin
      resp_valid_q <= in_demand;
      resp_hit_q   <= in_demand && hit;
      mem_rd_q     <= fill_rd;
      mem_wr_q     <= in_demand && wr_q;
      if (upd_en) begin
        mem_addr_q <= lk_addr;
      end
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign mem_rd     = mem_rd_q;
  assign mem_wr     = mem_wr_q;
  assign mem_addr   = mem_addr_q;

  // Counters; prefetch fills reach only the read counter (R8, R11).
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign cnt_inc[CNT_HIT]  = in_demand && hit;
  assign cnt_inc[CNT_MISS] = in_demand && !hit;
  assign cnt_inc[CNT_RD]   = fill_rd;
  assign cnt_inc[CNT_WR]   = in_demand && wr_q;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      pwc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (cnt_inc[g]),
        .count (cnt_val[g])
      );
    end
  endgenerate

  assign hit_count  = cnt_val[CNT_HIT];
  assign miss_count = cnt_val[CNT_MISS];
  assign rd_count   = cnt_val[CNT_RD];
  assign wr_count   = cnt_val[CNT_WR];
endmodule

// File: rtl/pwc_cache_ctrl_chk.sv
module pwc_cache_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] rd_count,
  input logic [CNT_W-1:0] wr_count
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hit_count == '0 && miss_count == '0 &&
                    rd_count == '0 && wr_count == '0 && !resp_valid));

  p_write_through_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> resp_valid);

  p_miss_reads_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> mem_rd);

  p_hit_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !mem_rd);

  p_pf_after_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !resp_valid) |-> $past(resp_valid && !resp_hit));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_resp_timing_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 resp_valid);

  p_no_overflow_hit_r11: assert property (@(posedge clk) disable iff (rst)
    hit_count >= $past(hit_count));

  p_no_overflow_rd_r11: assert property (@(posedge clk) disable iff (rst)
    rd_count >= $past(rd_count));
endmodule

bind pwc_cache_ctrl pwc_cache_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .hit_count  (hit_count),
  .miss_count (miss_count),
  .rd_count   (rd_count),
  .wr_count   (wr_count)
);

// File: tb/pwc_cache_ctrl_test.sv
module pwc_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pf_enable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [47:0] req_addr = '0;

  logic        req_ready, resp_valid, resp_hit, mem_rd, mem_wr;
  logic [47:0] mem_addr;
  logic [31:0] hit_count, miss_count, rd_count, wr_count;

  logic        fa_ready, fa_rv, fa_rh, fa_rd, fa_wr;
  logic [47:0] fa_addr;
  logic [31:0] fa_hits, fa_miss, fa_rds, fa_wrs;

  logic        dm_ready, dm_rv, dm_rh, dm_rd, dm_wr;
  logic [47:0] dm_addr;
  logic [2:0]  dm_hits, dm_miss, dm_rds, dm_wrs;

  always #2 clk = ~clk;   // 250 MHz

  pwc_cache_ctrl uut (
    .clk(clk), .rst(rst), .pf_enable(pf_enable),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .hit_count(hit_count), .miss_count(miss_count),
    .rd_count(rd_count), .wr_count(wr_count)
  );

  // Fully associative: one set of 8 ways.
  pwc_cache_ctrl #(.WAYS(8)) uut_fa (
    .clk(clk), .rst(rst), .pf_enable(pf_enable),
    .req_valid(req_valid), .req_ready(fa_ready),
    .req_write(req_write), .req_addr(req_addr),
    .resp_valid(fa_rv), .resp_hit(fa_rh),
    .mem_rd(fa_rd), .mem_wr(fa_wr), .mem_addr(fa_addr),
    .hit_count(fa_hits), .miss_count(fa_miss),
    .rd_count(fa_rds), .wr_count(fa_wrs)
  );

  // Direct mapped with 3-bit counters.
  pwc_cache_ctrl #(.WAYS(1), .CNT_W(3)) uut_dm (
    .clk(clk), .rst(rst), .pf_enable(pf_enable),
    .req_valid(req_valid), .req_ready(dm_ready),
    .req_write(req_write), .req_addr(req_addr),
    .resp_valid(dm_rv), .resp_hit(dm_rh),
    .mem_rd(dm_rd), .mem_wr(dm_wr), .mem_addr(dm_addr),
    .hit_count(dm_hits), .miss_count(dm_miss),
    .rd_count(dm_rds), .wr_count(dm_wrs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          rd_seen, wr_seen, resp_seen;
  logic        hit_seen, ready_n1;
  logic [47:0] last_rd_addr;

  always @(negedge clk) begin
    if (mem_rd) begin
      rd_seen++;
      last_rd_addr = mem_addr;
    end
    if (mem_wr) wr_seen++;
    if (resp_valid) begin
      resp_seen++;
      hit_seen = resp_hit;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic pf, input logic wr, input logic [47:0] addr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_seen = 0; wr_seen = 0; resp_seen = 0; hit_seen = 1'bx;
    pf_enable = pf; req_write = wr; req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    ready_n1 = req_ready;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Vector: {pf, wr, addr[47:0], exp_hit, exp_rd[1:0], exp_wr}
  // Config: 4 sets x 2 ways, 4-byte blocks; set = addr[3:2], tag = addr[47:4].
  localparam int NV = 16;
  localparam logic [53:0] VEC [NV] = '{
    {1'b0, 1'b0, 48'h00, 1'b0, 2'd1, 1'b0}, // R1 cold miss
    {1'b0, 1'b0, 48'h03, 1'b1, 2'd0, 1'b0}, // R2 offset only
    {1'b0, 1'b1, 48'h10, 1'b0, 2'd1, 1'b1}, // R5 write miss, R9 empty way
    {1'b0, 1'b0, 48'h00, 1'b1, 2'd0, 1'b0}, // R9 first line kept
    {1'b0, 1'b0, 48'h20, 1'b0, 2'd1, 1'b0}, // R3 evicts 0x10
    {1'b0, 1'b0, 48'h10, 1'b0, 2'd1, 1'b0}, // R3 0x10 was evicted
    {1'b0, 1'b0, 48'h20, 1'b1, 2'd0, 1'b0}, // R3 0x20 survived
    {1'b0, 1'b1, 48'h20, 1'b1, 2'd0, 1'b1}, // R4 write hit
    {1'b1, 1'b0, 48'h04, 1'b0, 2'd2, 1'b0}, // R6 miss + prefetch 0x08
    {1'b1, 1'b0, 48'h08, 1'b1, 2'd0, 1'b0}, // R8 prefetched line hits
    {1'b1, 1'b0, 48'h0C, 1'b0, 2'd1, 1'b0}, // R7 target 0x10 resident
    {1'b1, 1'b0, 48'h40, 1'b0, 2'd2, 1'b0}, // R7 LRU untouched: evicts 0x10
    {1'b1, 1'b0, 48'h20, 1'b1, 2'd0, 1'b0}, // R7 0x20 still present
    {1'b1, 1'b1, 48'h80, 1'b0, 2'd2, 1'b1}, // R8 write miss + prefetch fill
    {1'b1, 1'b0, 48'h44, 1'b1, 2'd0, 1'b0}, // R8 prefetched 0x44 hits
    {1'b1, 1'b0, 48'h04, 1'b0, 2'd1, 1'b0}  // R8 prefetch fill evicted 0x04
  };

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", req_ready, 1);
    check("R1 resp_valid", resp_valid, 0);
    check("R1 counters", {hit_count, miss_count} | {rd_count, wr_count}, 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][53], VEC[i][52], VEC[i][51:4]);
      check($sformatf("R3/R8 hit vec %0d", i), hit_seen, VEC[i][3]);
      check($sformatf("R5/R6 reads vec %0d", i), rd_seen, VEC[i][2:1]);
      check($sformatf("R4 writes vec %0d", i), wr_seen, VEC[i][0]);
    end

    // R8 prefetch fills reach only the read counter; R11 counter values
    check("R8 hit_count", hit_count, 7);
    check("R8 miss_count", miss_count, 9);
    check("R11 rd_count", rd_count, 12);
    check("R4 wr_count", wr_count, 3);

    // R1 after a second reset, everything clear and empty
    do_reset();
    check("R1 counters after reset", {hit_count, miss_count} | {rd_count, wr_count}, 0);

    // R6 wrap of prefetch address; R10 handshake timing
    access(1'b1, 1'b0, 48'hFFFF_FFFF_FFFC);
    check("R1 first access misses", hit_seen, 0);
    check("R6 wrap reads", rd_seen, 2);
    check("R6 wrap prefetch address", last_rd_addr, 48'h0);
    check("R10 ready low after accept", ready_n1, 0);
    check("R10 one response", resp_seen, 1);
    access(1'b0, 1'b0, 48'h0);
    check("R6 wrapped block resident", hit_seen, 1);

    // R12 associativity variants, R11 saturation
    do_reset();
    for (int i = 0; i < 10; i++) begin
      access(1'b0, 1'b0, (i % 2 == 0) ? 48'h00 : 48'h20);
    end
    check("R12 fully assoc hits", fa_hits, 8);
    check("R12 fully assoc misses", fa_miss, 2);
    check("R12 2-way hits", hit_count, 8);
    check("R12 direct mapped hits", dm_hits, 0);
    check("R11 saturated misses", dm_miss, 7);
    check("R11 saturated reads", dm_rds, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule